// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a flash controller. It treats every bus write aimed at the flash address space as one cycle of a command sequence. No write ever passes through as plain data. Each cycle is compared with the pattern expected at that point in the sequence. A wrong offset, a wrong data byte or a cycle out of order raises a sticky sequence-error flag, and the decoder goes back to waiting for a first cycle.

Erase and program each need leading unlock cycles, so a single stray write cannot start them. When one of these sequences completes, the decoder issues a one-cycle command to the bank controller. It then holds command mode and busy until the bank reports completion. Clear-status and enter-page-mode are single writes that take effect at once and never enter command mode.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, command mode, busy, sequence error, operation error, page mode and the bank command strobe are all low.
- R2: Writing 0xAA at offset 0x5554, then 0x55 at 0xAAA8, then 0xA0 at 0x5554, then any data at any offset issues a program request. The request is `bank_cmd_valid` high for one cycle with `bank_cmd_op` = 2'b10, and the fourth write's address and data on `bank_cmd_addr` and `bank_cmd_data`. It appears in the cycle after the fourth write.
- R3: Writing 0xAA@0x5554, 0x55@0xAAA8, 0x80@0x5554, 0xAA@0x5554, 0x55@0xAAA8, then 0x30 at a sector offset issues an erase request with `bank_cmd_op` = 2'b01 and the sector offset on `bank_cmd_addr`.
- R4: Command mode and busy rise together with the bank command strobe. They stay high until `bank_done` is sampled, and fall in the cycle after it.
- R5: When `bank_done` is sampled together with `bank_fail`, the operation-error flag is set and stays set until a clear-status command.
- R6: A write with a wrong offset or wrong data for the current step sets the sticky sequence-error flag and returns the decoder to its first-cycle state. A correct sequence written next is then accepted.
- R7: A single write of 0xF5 at 0x5554 clears both the sequence-error and operation-error flags, without entering command mode.
- R8: A single write of 0x50 or 0x5D at 0x5554 sets the page-mode flag without entering command mode. Page mode is cleared when a bank command is issued.
- R9: While busy, a clear-status write clears the error flags but leaves busy high. Any other write sets the sequence error, issues no command and leaves busy high.
- R10: A lone write of 0xA0 or 0x30, without the unlock cycles, issues no bank command and sets the sequence-error flag.
- R11: Reset in the middle of a sequence abandons it, so the next write is decoded as a first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write cycle strobe |
| wr_addr | input | ADDR_W | Write offset within flash space |
| wr_data | input | DATA_W | Write data |
| bank_done | input | 1 | Bank operation finished |
| bank_fail | input | 1 | Bank operation failed (valid with bank_done) |
| bank_cmd_valid | output | 1 | One-cycle bank command strobe |
| bank_cmd_op | output | 2 | 01 erase, 10 program |
| bank_cmd_addr | output | ADDR_W | Sector or program offset |
| bank_cmd_data | output | DATA_W | Program data |
| cmd_mode | output | 1 | Command mode active |
| busy | output | 1 | Bank operation in progress |
| seq_err | output | 1 | Sticky sequence error |
| op_err | output | 1 | Sticky operation error |
| page_mode | output | 1 | Page mode entered |

## Verification
The hardest situation to reach is a write, or a clear-status, that lands while an erase is still outstanding. The bench gets there by completing a full six-cycle erase and holding `bank_done` low. It then injects a stray write and a clear-status before releasing the bank. It also reaches the sixth erase step and makes it fail on its data byte, which proves the decoder falls back to the first-cycle state at that depth.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_ERA_PRE,
        ST_ERA_UNL1,
        ST_ERA_UNL2,
        ST_PROG,
        ST_BUSY
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_ERASE = 2'b01,
        OP_PROG  = 2'b10
    } bank_op_e;

    typedef struct packed {
        logic at_a;
        logic at_b;
        logic d_aa;
        logic d_55;
        logic d_80;
        logic d_a0;
        logic d_30;
        logic d_f5;
        logic d_page;
    } cyc_class_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] OFS_A = 16'h5554,
    parameter logic [ADDR_W-1:0] OFS_B = 16'hAAA8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output cyc_class_t        cls_o
);
    function automatic logic is_byte(input logic [DATA_W-1:0] d, input logic [7:0] v);
        return d == DATA_W'(v);
    endfunction

    always_comb begin
        cls_o.at_a   = (addr_i == OFS_A);
        cls_o.at_b   = (addr_i == OFS_B);
        cls_o.d_aa   = is_byte(data_i, 8'hAA);
        cls_o.d_55   = is_byte(data_i, 8'h55);
        cls_o.d_80   = is_byte(data_i, 8'h80);
        cls_o.d_a0   = is_byte(data_i, 8'hA0);
        cls_o.d_30   = is_byte(data_i, 8'h30);
        cls_o.d_f5   = is_byte(data_i, 8'hF5);
        cls_o.d_page = is_byte(data_i, 8'h50) || is_byte(data_i, 8'h5D);
    end
endmodule

// File: rtl/flash_cmd_status.sv
module flash_cmd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_seq_i,
    input  logic set_op_i,
    input  logic clr_i,
    input  logic set_page_i,
    input  logic clr_page_i,
    output logic seq_err_o,
    output logic op_err_o,
    output logic page_o
);
    typedef struct packed {
        logic seq_err;
        logic op_err;
        logic page;
    } flags_t;

    flags_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.seq_err = 1'b0;
            st_d.op_err  = 1'b0;
        end
        if (set_seq_i) st_d.seq_err = 1'b1;
        if (set_op_i)  st_d.op_err  = 1'b1;
        if (clr_page_i) st_d.page = 1'b0;
        if (set_page_i) st_d.page = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seq_err_o = st_q.seq_err;
    assign op_err_o  = st_q.op_err;
    assign page_o    = st_q.page;

    // R6
    seq_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err_o && !clr_i |=> seq_err_o);
    // R5
    op_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_err_o && !clr_i |=> op_err_o);
    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i && !set_seq_i && !set_op_i |=> !seq_err_o && !op_err_o);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bank_done,
    input  logic              bank_fail,
    output logic              bank_cmd_valid,
    output logic [1:0]        bank_cmd_op,
    output logic [ADDR_W-1:0] bank_cmd_addr,
    output logic [DATA_W-1:0] bank_cmd_data,
    output logic              cmd_mode,
    output logic              busy,
    output logic              seq_err,
    output logic              op_err,
    output logic              page_mode
);
    typedef struct packed {
        seq_state_e        state;
        logic              cmd_valid;
        bank_op_e          cmd_op;
        logic [ADDR_W-1:0] cmd_addr;
        logic [DATA_W-1:0] cmd_data;
    } seq_regs_t;

    seq_regs_t  r_d, r_q;
    cyc_class_t cls;
    logic set_seq, set_op, clr_stat, set_page, clr_page;

    flash_cmd_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .addr_i (wr_addr),
        .data_i (wr_data),
        .cls_o  (cls)
    );

    always_comb begin
        r_d       = r_q;
        r_d.cmd_valid = 1'b0;
        set_seq   = 1'b0;
        set_op    = 1'b0;
        clr_stat  = 1'b0;
        set_page  = 1'b0;
        clr_page  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: if (wr_valid) begin
                if (cls.at_a && cls.d_aa)        r_d.state = ST_UNL1;
                else if (cls.at_a && cls.d_f5)   clr_stat  = 1'b1;
                else if (cls.at_a && cls.d_page) set_page  = 1'b1;
                else                             set_seq   = 1'b1;
            end
            ST_UNL1, ST_ERA_UNL1: if (wr_valid) begin
                if (cls.at_b && cls.d_55)
                    r_d.state = (r_q.state == ST_UNL1) ? ST_UNL2 : ST_ERA_UNL2;
                else begin
                    r_d.state = ST_IDLE;
                    set_seq   = 1'b1;
                end
            end
            ST_UNL2: if (wr_valid) begin
                if (cls.at_a && cls.d_80)      r_d.state = ST_ERA_PRE;
                else if (cls.at_a && cls.d_a0) r_d.state = ST_PROG;
                else begin
                    r_d.state = ST_IDLE;
                    set_seq   = 1'b1;
                end
            end
            ST_ERA_PRE: if (wr_valid) begin
                if (cls.at_a && cls.d_aa) r_d.state = ST_ERA_UNL1;
                else begin
                    r_d.state = ST_IDLE;
                    set_seq   = 1'b1;
                end
            end
            ST_ERA_UNL2: if (wr_valid) begin
                if (cls.d_30) begin
                    r_d.state     = ST_BUSY;
                    r_d.cmd_valid = 1'b1;
                    r_d.cmd_op    = OP_ERASE;
                    r_d.cmd_addr  = wr_addr;
                    r_d.cmd_data  = wr_data;
                    clr_page      = 1'b1;
                end else begin
                    r_d.state = ST_IDLE;
                    set_seq   = 1'b1;
                end
            end
            ST_PROG: if (wr_valid) begin
                r_d.state     = ST_BUSY;
                r_d.cmd_valid = 1'b1;
                r_d.cmd_op    = OP_PROG;
                r_d.cmd_addr  = wr_addr;
                r_d.cmd_data  = wr_data;
                clr_page      = 1'b1;
            end
            ST_BUSY: begin
                if (wr_valid) begin
                    if (cls.at_a && cls.d_f5) clr_stat = 1'b1;
                    else                      set_seq  = 1'b1;
                end
                if (bank_done) begin
                    r_d.state = ST_IDLE;
                    set_op    = bank_fail;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= ST_IDLE;
            r_q.cmd_valid <= 1'b0;
            r_q.cmd_op    <= OP_NONE;
            r_q.cmd_addr  <= '0;
            r_q.cmd_data  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    flash_cmd_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_seq_i  (set_seq),
        .set_op_i   (set_op),
        .clr_i      (clr_stat),
        .set_page_i (set_page),
        .clr_page_i (clr_page),
        .seq_err_o  (seq_err),
        .op_err_o   (op_err),
        .page_o     (page_mode)
    );

    assign bank_cmd_valid = r_q.cmd_valid;
    assign bank_cmd_op    = r_q.cmd_op;
    assign bank_cmd_addr  = r_q.cmd_addr;
    assign bank_cmd_data  = r_q.cmd_data;
    assign busy           = (r_q.state == ST_BUSY);
    assign cmd_mode       = busy;

    // R4
    cmd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_cmd_valid |-> busy);
    // R4
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> bank_cmd_valid);
    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bank_done |=> busy);
    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_cmd_valid |=> !bank_cmd_valid);
    // R9
    no_cmd_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_valid && !bank_done |=> !bank_cmd_valid && busy);
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
    localparam int AW = 16;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic bank_done = 1'b0, bank_fail = 1'b0;
    logic bank_cmd_valid, cmd_mode, busy, seq_err, op_err, page_mode;
    logic [1:0] bank_cmd_op;
    logic [AW-1:0] bank_cmd_addr;
    logic [DW-1:0] bank_cmd_data;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW)) u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .bank_done(bank_done), .bank_fail(bank_fail),
        .bank_cmd_valid(bank_cmd_valid), .bank_cmd_op(bank_cmd_op),
        .bank_cmd_addr(bank_cmd_addr), .bank_cmd_data(bank_cmd_data),
        .cmd_mode(cmd_mode), .busy(busy), .seq_err(seq_err), .op_err(op_err),
        .page_mode(page_mode)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic finish_bank(input logic fail);
        @(negedge clk);
        bank_done = 1'b1; bank_fail = fail;
        @(negedge clk);
        bank_done = 1'b0; bank_fail = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic unlock();
        wr(16'h5554, 8'hAA);
        wr(16'hAAA8, 8'h55);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "flags", {bank_cmd_valid, cmd_mode, busy, seq_err, op_err, page_mode}, 0);
    endtask

    task automatic t_program();
        unlock();
        wr(16'h5554, 8'hA0);
        chk("R2", "no strobe before data", bank_cmd_valid, 0);
        wr(16'h1234, 8'h6B);
        chk("R2", "strobe", bank_cmd_valid, 1);
        chk("R2", "op", bank_cmd_op, 2'b10);
        chk("R2", "addr", bank_cmd_addr, 16'h1234);
        chk("R2", "data", bank_cmd_data, 8'h6B);
        chk("R4", "busy+cmd_mode", {busy, cmd_mode}, 2'b11);
        @(negedge clk);
        chk("R2", "strobe one cycle", bank_cmd_valid, 0);
        repeat (3) @(negedge clk);
        chk("R4", "held busy", {busy, cmd_mode}, 2'b11);
        finish_bank(1'b0);
        chk("R4", "released", {busy, cmd_mode}, 2'b00);
        chk("R5", "no op error", op_err, 0);
    endtask

    task automatic t_erase_with_busy_writes();
        unlock();
        wr(16'h5554, 8'h80);
        unlock();
        chk("R3", "no strobe yet", bank_cmd_valid, 0);
        wr(16'h4000, 8'h30);
        chk("R3", "strobe", bank_cmd_valid, 1);
        chk("R3", "op", bank_cmd_op, 2'b01);
        chk("R3", "sector", bank_cmd_addr, 16'h4000);
        wr(16'h5554, 8'hAA);
        chk("R9", "stray write error", seq_err, 1);
        chk("R9", "busy kept", busy, 1);
        chk("R9", "no new cmd", bank_cmd_valid, 0);
        wr(16'h5554, 8'hF5);
        chk("R9", "clear during busy", seq_err, 0);
        chk("R9", "busy not cleared", busy, 1);
        finish_bank(1'b1);
        chk("R5", "op error set", op_err, 1);
        chk("R4", "released", busy, 0);
        repeat (2) @(negedge clk);
        chk("R5", "op error sticky", op_err, 1);
        wr(16'h5554, 8'hF5);
        chk("R7", "op error cleared", op_err, 0);
        chk("R7", "no cmd mode", cmd_mode, 0);
    endtask

    task automatic t_errors();
        wr(16'h5554, 8'hAA);
        wr(16'hAAA9, 8'h55);
        chk("R6", "bad offset", seq_err, 1);
        wr(16'h5554, 8'hF5);
        chk("R7", "cleared", seq_err, 0);
        unlock();
        wr(16'h5554, 8'h80);
        unlock();
        wr(16'h4000, 8'h31);
        chk("R6", "bad erase data", {seq_err, bank_cmd_valid, busy}, 3'b100);
        unlock();
        wr(16'h5554, 8'hA0);
        wr(16'h0010, 8'h01);
        chk("R6", "recovers after error", {bank_cmd_valid, bank_cmd_op}, 3'b110);
        finish_bank(1'b0);
        wr(16'h5554, 8'hF5);
        wr(16'h5554, 8'hA0);
        chk("R10", "lone A0", {seq_err, bank_cmd_valid, busy}, 3'b100);
        wr(16'h5554, 8'hF5);
        wr(16'h4000, 8'h30);
        chk("R10", "lone 30", {seq_err, bank_cmd_valid, busy}, 3'b100);
        wr(16'h5554, 8'hF5);
        wr(16'hAAA8, 8'h55);
        chk("R6", "out of order", seq_err, 1);
        wr(16'h5554, 8'hF5);
    endtask

    task automatic t_page();
        wr(16'h5554, 8'h50);
        chk("R8", "page 50", {page_mode, cmd_mode, seq_err}, 3'b100);
        do_reset();
        wr(16'h5554, 8'h5D);
        chk("R8", "page 5D", {page_mode, cmd_mode}, 2'b10);
        unlock();
        wr(16'h5554, 8'hA0);
        wr(16'h0002, 8'h00);
        chk("R8", "page cleared by cmd", page_mode, 0);
        finish_bank(1'b0);
    endtask

    task automatic t_reset_mid();
        unlock();
        wr(16'h5554, 8'hA0);
        do_reset();
        wr(16'h0100, 8'h77);
        chk("R11", "abandoned", {bank_cmd_valid, busy, seq_err}, 3'b001);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_program();
                t_erase_with_busy_writes();
                t_errors();
                t_page();
                t_reset_mid();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule